// File: doc/BRIEF.md
# Half-Duplex Transmit Access Controller

This block decides when an Ethernet MAC may put a frame on the wire. A framer holds `tx_req` high while a frame is waiting. The controller waits until the medium has been quiet for a full interframe gap and then raises `tx_go`. It stays in transmit until the framer reports the end of the frame, or until a collision is seen in half duplex. After a collision it holds `jam_active` high for the jam period. It then pulses `retry` and waits a random number of slot times before deferring again. If every attempt of a frame collides, the frame is abandoned and `excess_abort` pulses.

All timing is counted in bit times. At 100 Mb/s, one `bit_tick` is one bit time. At 10 Mb/s, `SLOW_DIV` ticks make one bit time.

The random slot count comes from a free-running 16-bit LFSR. It is masked to an exponent that grows with the attempt number. A strap that is captured while reset is held picks the exponent ceiling: either the usual ceiling of ten, or a reduced ceiling of four.

Top module: `tx_backoff_ctl`

## Requirements
- R1: While reset is held and in the first cycle after it, `tx_go`, `jam_active`, `retry` and `excess_abort` are all low.
- R2: With the line idle and `bit_tick` high every cycle at 100 Mb/s, `tx_go` rises 1 + IFG_BITS cycles after `tx_req` is first sampled high.
- R3: Carrier sensed during the gap clears the gap count. `tx_go` then rises IFG_BITS bit times after the first idle cycle that follows the carrier.
- R4: A collision sampled while `tx_go` is high in half duplex drops `tx_go` and holds `jam_active` high for exactly JAM_BITS bit times.
- R5: When a jam ends, `retry` pulses for one cycle. `tx_go` then returns after r*SLOT_BITS + IFG_BITS bit times, where r is in [0, 2^k - 1] and k = min(n, EXP_LIMIT) for the n-th collision of the frame.
- R6: When `limit4_strap` is 1 during reset, k = min(n, CAPPED_LIMIT), so r never exceeds 15 with the default CAPPED_LIMIT of 4.
- R7: The jam that follows collision number MAX_ATTEMPTS ends with a one-cycle `excess_abort` and no `retry`. The controller then returns to idle, and `tx_go` stays low while `tx_req` is low.
- R8: With `full_duplex` high, `col` has no effect: `tx_go` stays high and `jam_active` stays low.
- R9: With `speed_100` low, one bit time takes SLOW_DIV `bit_tick` pulses. The gap and the jam stretch by that factor, within one bit-time phase.
- R10: While `bit_tick` is low, none of the counters advance, so a deferring request never reaches `tx_go`.
- R11: `tx_done` while `tx_go` is high ends the transmission: `tx_go` is low in the next cycle. It also clears the attempt count, so the first collision of the next frame uses k = 1.
- R12: `tx_go` and `jam_active` are never high together, and `retry` and `excess_abort` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is captured while it is low |
| limit4_strap | input | 1 | 1 selects the backoff exponent ceiling CAPPED_LIMIT |
| full_duplex | input | 1 | 1 makes the controller ignore `col` |
| speed_100 | input | 1 | 1: one tick per bit time; 0: SLOW_DIV ticks per bit time |
| bit_tick | input | 1 | Timing strobe |
| tx_req | input | 1 | Frame waiting to be sent |
| tx_done | input | 1 | Framer has finished the current frame |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_go | output | 1 | Transmission permitted |
| jam_active | output | 1 | Jam pattern is to be sent |
| retry | output | 1 | One-cycle pulse: backoff started for another attempt |
| excess_abort | output | 1 | One-cycle pulse: frame abandoned after too many collisions |

## Verification
The bench builds the controller with IFG_BITS 6, JAM_BITS 3, SLOT_BITS 4 and SLOW_DIV 3. It keeps MAX_ATTEMPTS at 16 and EXP_LIMIT at 10.

The short gap, jam and slot keep each wait to a few cycles. This makes a full run of sixteen collisions affordable, up to the largest 1023-slot backoff. The abort and both exponent ceilings can therefore be reached in both strap settings.

Because the backoff draw is random, each measured delay is checked to be a whole number of slots past the gap and to lie within the allowed range.

// File: rtl/tx_backoff_ctl.sv
module tx_backoff_ctl #(
  parameter int IFG_BITS     = 96,
  parameter int JAM_BITS     = 32,
  parameter int SLOT_BITS    = 512,
  parameter int MAX_ATTEMPTS = 16,
  parameter int EXP_LIMIT    = 10,
  parameter int CAPPED_LIMIT = 4,
  parameter int SLOW_DIV     = 10,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic limit4_strap,
  input  logic full_duplex,
  input  logic speed_100,
  input  logic bit_tick,
  input  logic tx_req,
  input  logic tx_done,
  input  logic crs,
  input  logic col,
  output logic tx_go,
  output logic jam_active,
  output logic retry,
  output logic excess_abort
);

  localparam int CNT_MAX = (IFG_BITS > JAM_BITS) ?
                           ((IFG_BITS > SLOT_BITS) ? IFG_BITS : SLOT_BITS) :
                           ((JAM_BITS > SLOT_BITS) ? JAM_BITS : SLOT_BITS);
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int AW = $clog2(MAX_ATTEMPTS + 1);
  localparam int RW = EXP_LIMIT;
  localparam int DW = $clog2(SLOW_DIV + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEFER, S_XMIT, S_JAM, S_BACKOFF} st_t;

  st_t           st_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] slots_q;
  logic [AW-1:0] att_q;
  logic [DW-1:0] div_q;
  logic [15:0]   lfsr_q;
  logic          cap_q;

  logic          bt;
  logic [AW-1:0] lim, k;
  logic [RW-1:0] mask, pick;

  assign bt         = bit_tick & (speed_100 | (div_q == DW'(SLOW_DIV - 1)));
  assign lim        = cap_q ? AW'(CAPPED_LIMIT) : AW'(EXP_LIMIT);
  assign k          = (att_q < lim) ? att_q : lim;
  assign pick       = lfsr_q[RW-1:0] & mask;
  assign tx_go      = (st_q == S_XMIT);
  assign jam_active = (st_q == S_JAM);

  always_comb
    for (int i = 0; i < RW; i++) mask[i] = (i < int'(k));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q  <= '0;
      lfsr_q <= LFSR_SEED;
      cap_q  <= limit4_strap;
    end else begin
      lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
      if (bit_tick) div_q <= (div_q == DW'(SLOW_DIV - 1)) ? '0 : div_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_q         <= S_IDLE;
      cnt_q        <= '0;
      slots_q      <= '0;
      att_q        <= '0;
      retry        <= 1'b0;
      excess_abort <= 1'b0;
    end else begin
      retry        <= 1'b0;
      excess_abort <= 1'b0;
      case (st_q)
        S_IDLE:
          if (tx_req) begin
            st_q  <= S_DEFER;
            cnt_q <= '0;
          end
        S_DEFER:
          if (crs) cnt_q <= '0;
          else if (bt) begin
            if (cnt_q == CW'(IFG_BITS - 1)) begin
              st_q  <= S_XMIT;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        S_XMIT:
          if (col && !full_duplex) begin
            st_q  <= S_JAM;
            cnt_q <= '0;
            att_q <= att_q + 1'b1;
          end else if (tx_done) begin
            st_q  <= S_IDLE;
            att_q <= '0;
          end
        S_JAM:
          if (bt) begin
            if (cnt_q == CW'(JAM_BITS - 1)) begin
              cnt_q <= '0;
              if (att_q == AW'(MAX_ATTEMPTS)) begin
                excess_abort <= 1'b1;
                att_q        <= '0;
                st_q         <= S_IDLE;
              end else begin
                retry   <= 1'b1;
                slots_q <= pick;
                st_q    <= (pick == '0) ? S_DEFER : S_BACKOFF;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
        S_BACKOFF:
          if (bt) begin
            if (cnt_q == CW'(SLOT_BITS - 1)) begin
              cnt_q   <= '0;
              slots_q <= slots_q - 1'b1;
              if (slots_q == RW'(1)) st_q <= S_DEFER;
            end else cnt_q <= cnt_q + 1'b1;
          end
        default: st_q <= S_IDLE;
      endcase
    end

endmodule

// File: rtl/tx_backoff_ctl_chk.sv
module tx_backoff_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic full_duplex,
  input logic crs,
  input logic col,
  input logic tx_go,
  input logic jam_active,
  input logic retry,
  input logic excess_abort
);

  assert_go_jam_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_go && jam_active));

  assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry && excess_abort));

  assert_go_after_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_go) |-> $past(!crs));

  assert_jam_from_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> ($past(tx_go) && $past(col) && !$past(full_duplex)));

  assert_retry_after_jam_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry |-> ($past(jam_active) && !jam_active));

  assert_retry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retry |=> !retry);

  assert_abort_after_jam_R7: assert property (@(posedge clk) disable iff (!rst_n)
    excess_abort |-> ($past(jam_active) && !tx_go));

  assert_fd_no_jam_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_go && full_duplex) |=> !jam_active);

endmodule

bind tx_backoff_ctl tx_backoff_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .crs(crs), .col(col),
  .tx_go(tx_go), .jam_active(jam_active), .retry(retry),
  .excess_abort(excess_abort)
);

// File: tb/tx_backoff_ctl_tb.sv
module tx_backoff_ctl_tb;

  localparam int IFG  = 6;
  localparam int JAM  = 3;
  localparam int SLOT = 4;
  localparam int MAXA = 16;
  localparam int EXPL = 10;
  localparam int CAPL = 4;
  localparam int DIV  = 3;
  localparam int NV   = 6;
  // [11:8] carrier offset (0 = none), [7:4] collisions, [0] full duplex
  localparam logic [11:0] VEC [NV] = '{12'h000, 12'h210, 12'h630,
                                       12'h021, 12'h350, 12'h100};

  logic clk = 0, rst_n = 0, limit4_strap = 0, full_duplex = 0, speed_100 = 1;
  logic bit_tick = 1, tx_req = 0, tx_done = 0, crs = 0, col = 0;
  logic tx_go, jam_active, retry, excess_abort;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  always #5 clk = ~clk;

  tx_backoff_ctl #(.IFG_BITS(IFG), .JAM_BITS(JAM), .SLOT_BITS(SLOT),
    .MAX_ATTEMPTS(MAXA), .EXP_LIMIT(EXPL), .CAPPED_LIMIT(CAPL), .SLOW_DIV(DIV))
  u_dut (.clk(clk), .rst_n(rst_n), .limit4_strap(limit4_strap),
    .full_duplex(full_duplex), .speed_100(speed_100), .bit_tick(bit_tick),
    .tx_req(tx_req), .tx_done(tx_done), .crs(crs), .col(col), .tx_go(tx_go),
    .jam_active(jam_active), .retry(retry), .excess_abort(excess_abort));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 0; limit4_strap = strap;
    repeat (3) @(negedge clk);
    chk(!tx_go && !jam_active && !retry && !excess_abort, "R1 in reset",
        {tx_go, jam_active, retry, excess_abort}, 0);
    rst_n = 1; limit4_strap = 0;
    @(negedge clk);
    chk(!tx_go && !jam_active && !retry && !excess_abort, "R1 after reset",
        {tx_go, jam_active, retry, excess_abort}, 0);
  endtask

  task automatic wait_go(output int n);
    n = 0;
    while (!tx_go && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic end_frame;
    tx_done = 1; tx_req = 0;
    @(negedge clk);
    tx_done = 0;
    chk(!tx_go, "R11 go cleared by done", tx_go, 0);
    repeat (2) @(negedge clk);
  endtask

  // called at a negedge with tx_go high; n is the collision number
  task automatic collide(input int n, input int lim, input bit last);
    int j, d, slots, kk;
    col = 1;
    @(negedge clk);
    col = 0;
    chk(!tx_go, "R4 go dropped", tx_go, 0);
    j = 0;
    while (jam_active && j < 5000) begin j++; @(negedge clk); end
    chk(j == JAM, "R4 jam length", j, JAM);
    if (last) begin
      chk(excess_abort && !retry, "R7 abort pulse", {excess_abort, retry}, 2);
      tx_req = 0;
      repeat (2 * IFG) @(negedge clk);
      chk(!tx_go && !excess_abort, "R7 idle after abort", {tx_go, excess_abort}, 0);
    end else begin
      chk(retry && !excess_abort, "R5 retry pulse", {retry, excess_abort}, 2);
      wait_go(d);
      kk = (n < lim) ? n : lim;
      slots = (d - IFG) / SLOT;
      chk(d >= IFG && (d - IFG) % SLOT == 0, "R5 whole slots", d, IFG + slots * SLOT);
      chk(slots <= (1 << kk) - 1, (lim == CAPL) ? "R6 capped range" : "R5 range",
          slots, (1 << kk) - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, off, ncol, expl;
    bit fd;
    do_reset(1'b0);

    for (int v = 0; v < NV; v++) begin
      off = int'(VEC[v][11:8]); ncol = int'(VEC[v][7:4]); fd = VEC[v][0];
      full_duplex = fd;
      tx_req = 1;
      lat = 0;
      while (!tx_go && lat < 200) begin
        @(negedge clk); lat++;
        crs = (off != 0 && lat == off);
      end
      crs = 0;
      expl = (off != 0) ? off + 1 + IFG : 1 + IFG;
      chk(lat == expl, (off != 0) ? "R3 gap restart" : "R2 gap latency", lat, expl);
      for (int c = 1; c <= ncol; c++) begin
        if (fd) begin
          col = 1;
          repeat (3) begin
            @(negedge clk);
            col = 0;
            chk(tx_go && !jam_active, "R8 col ignored", {tx_go, jam_active}, 2);
          end
        end else collide(c, EXPL, 1'b0);
      end
      end_frame();
    end
    full_duplex = 0;

    // R10: frozen tick
    bit_tick = 0; tx_req = 1;
    repeat (50) @(negedge clk);
    chk(!tx_go, "R10 no progress without tick", tx_go, 0);
    bit_tick = 1;
    wait_go(lat);
    chk(lat == IFG, "R10 resumes", lat, IFG);
    end_frame();

    // R9: 10 Mb/s scaling
    speed_100 = 0; tx_req = 1;
    wait_go(lat);
    chk(lat >= 2 + (IFG - 1) * DIV && lat <= 1 + IFG * DIV, "R9 slow gap", lat, 1 + IFG * DIV);
    col = 1;
    @(negedge clk);
    col = 0;
    lat = 0;
    while (jam_active && lat < 5000) begin lat++; @(negedge clk); end
    chk(lat >= (JAM - 1) * DIV + 1 && lat <= JAM * DIV, "R9 slow jam", lat, JAM * DIV);
    wait_go(lat);
    end_frame();
    speed_100 = 1;

    // R11: first collision of a new frame uses k=1
    tx_req = 1;
    wait_go(lat);
    collide(1, 1, 1'b0);
    end_frame();

    // R7: sixteen collisions, standard ceiling
    tx_req = 1;
    wait_go(lat);
    for (int c = 1; c <= MAXA; c++) collide(c, EXPL, c == MAXA);

    // R6: capped ceiling via strap
    do_reset(1'b1);
    tx_req = 1;
    wait_go(lat);
    for (int c = 1; c <= MAXA; c++) collide(c, CAPL, c == MAXA);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule